// File: doc/BRIEF.md
# Two-Wire Parallel Port Handshake Controller

This block sits on the port side of a parallel digital I/O link and talks to an external peripheral over three control wires and a data bus. The wires are a direction output, a control strobe driven by the port, and a flag driven by the peripheral. In write direction the port owns the bus. It waits for the peripheral to pull the flag low, which means it is ready for data. It then presents a word, pulls the strobe low to mark the data valid, and waits for the flag to rise as an acknowledge before it releases the strobe.

In read direction the bus is released. The port pulls the strobe low to show it is ready. The peripheral pulls the flag low to mark its data valid, and the port then latches the bus. Every edge of the sequence keeps a minimum spacing in microseconds. Each spacing is turned into a cycle count from a clock-frequency parameter, rounded up so that no minimum is ever undershot. On the host side there is a valid/ready word interface for each direction. An optional timeout ends any wait on the flag.

Top module: `pport_hs`

## Requirements
- R1: After reset the control strobe is high, direction is read (`port_dir`=1), the bus output enable is low, and `busy`, `err`, `rx_valid` are low.
- R2: After every change of `port_dir`, and after reset, no transfer starts and `tx_ready` stays low for at least the settle time of 1000 µs (ceil of SETTLE_US·CLK_HZ/1e6 cycles).
- R3: A write accepts a word only when `tx_valid` and `tx_ready` are both high. The port does not drive that word while the flag is high. The word appears on `bus_out` with `bus_oe`=1 no sooner than 40 µs after the flag goes low.
- R4: In a write, the strobe goes low no sooner than 30 µs after the data became valid, and `bus_out` stays unchanged while the strobe is low.
- R5: In a write, the flag is not sampled for the acknowledge until 40 µs after the strobe fell. An acknowledge that arrives early therefore still yields at least 75 µs of strobe-low time.
- R6: In a write, the strobe returns high no sooner than 35 µs after the flag rose. `busy` is high from acceptance until the transfer ends, and the strobe is high whenever `busy` is low.
- R7: In read direction, with the receive word empty, the port pulls the strobe low as ready. When the flag goes low it latches `bus_in` into `rx_data`, raises the strobe, and holds `rx_valid` with stable data until `rx_ready`. No new read starts while the word is unread.
- R8: `bus_oe` is low whenever `port_dir` is 1 (read).
- R9: A request on `dir_sel` takes effect only when the port is idle; `port_dir` holds still while `busy` is high.
- R10: When TIMEOUT_US is nonzero, a wait on the flag that lasts TIMEOUT_US aborts the transfer. The strobe goes high, `bus_oe` goes low, `busy` drops, and `err` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_sel | input | 1 | Requested direction, 1 = read, 0 = write |
| tx_valid | input | 1 | Host has a word to send |
| tx_ready | output | 1 | Port accepts the word this cycle |
| tx_data | input | DW | Word to send |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | DW | Received word |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse on a timeout abort |
| port_dir | output | 1 | Direction line to the peripheral, 1 = read |
| port_ctl | output | 1 | Control strobe, active low, idles high |
| port_flag | input | 1 | Peripheral flag, asynchronous |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_out | output | DW | Data driven toward the peripheral |
| bus_in | input | DW | Data sampled from the peripheral |

## Verification
The bench measures the spacing of each handshake edge at the pins and checks it against a window. The lower bound is the minimum; the upper bound allows only the synchronizer and the register latency. A design that skipped a phase timer, or sampled the flag too early, would give a strobe pulse of about half the required length when the acknowledge comes early. The bench also runs a peripheral that acknowledges late, to separate the release delay from the check delay. It asks for a direction change in the middle of a read, which a careless design would obey at once and so corrupt the bus. It leaves a received word unread, to catch a port that overwrites it. It also lets the flag stall in both write waits, where a faulty abort would leave the bus driven or the strobe low.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_WAITLO,
    ST_W_SETUP,
    ST_W_HOLD,
    ST_W_GAP,
    ST_W_WAITHI,
    ST_W_RET,
    ST_R_WAITV,
    ST_R_WAITI
  } hs_state_t;

  // microseconds to clock cycles, rounded up, never below one
  function automatic longint unsigned us_to_cycles(input longint unsigned us,
                                                   input longint unsigned hz);
    longint unsigned c;
    c = (us * hz + 64'd999_999) / 64'd1_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

  function automatic longint unsigned max2(input longint unsigned a,
                                           input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) st <= RST_VAL;
      else     st <= d;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) st <= {STAGES{RST_VAL}};
      else     st <= {st[STAGES-2:0], d};
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pport_timer.sv
module pport_timer #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pport_hs.sv
module pport_hs #(
  parameter int              DW                 = 8,
  parameter longint unsigned CLK_HZ             = 200_000_000,
  parameter longint unsigned SETTLE_US          = 1000,
  parameter longint unsigned FLAG_TO_DATA_US    = 40,
  parameter longint unsigned DATA_TO_CTL_US     = 30,
  parameter longint unsigned CTL_TO_CHECK_US    = 40,
  parameter longint unsigned FLAG_TO_RELEASE_US = 35,
  parameter longint unsigned TIMEOUT_US         = 0,
  parameter int              SYNC_STAGES        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_sel,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  output logic          err,
  output logic          port_dir,
  output logic          port_ctl,
  input  logic          port_flag,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  input  logic [DW-1:0] bus_in
);
  import pport_pkg::*;

  localparam longint unsigned C_SETTLE = us_to_cycles(SETTLE_US, CLK_HZ);
  localparam longint unsigned C_SETUP  = us_to_cycles(FLAG_TO_DATA_US, CLK_HZ);
  localparam longint unsigned C_HOLD   = us_to_cycles(DATA_TO_CTL_US, CLK_HZ);
  localparam longint unsigned C_GAP    = us_to_cycles(CTL_TO_CHECK_US, CLK_HZ);
  localparam longint unsigned C_RET    = us_to_cycles(FLAG_TO_RELEASE_US, CLK_HZ);
  localparam longint unsigned C_TMO    = us_to_cycles(TIMEOUT_US, CLK_HZ);
  localparam longint unsigned C_MAX    =
    max2(max2(max2(C_SETTLE, C_SETUP), max2(C_HOLD, C_GAP)), max2(C_RET, C_TMO));
  localparam int   CW     = $clog2(C_MAX + 1);
  localparam logic TMO_EN = (TIMEOUT_US != 0);

  hs_state_t     state, state_d;
  logic          dir_q, ctl_q, oe_q, busy_q, err_q, rx_valid_q;
  logic [DW-1:0] tx_word, bus_q, rx_data_q;
  logic          flag_s;
  logic          ph_load, wt_load, settle_load;
  logic [CW-1:0] ph_val;
  logic          ph_done, wt_done, settle_done, timeout;
  logic          accept, drive, ctl_fall, ctl_rise, latch, abort;

  pport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(port_flag), .q(flag_s)
  );

  pport_timer #(.W(CW), .RST_VAL(CW'(C_SETTLE))) u_settle (
    .clk(clk), .rst(rst), .load(settle_load), .load_val(CW'(C_SETTLE)),
    .done(settle_done)
  );

  pport_timer #(.W(CW), .RST_VAL('0)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .done(ph_done)
  );

  pport_timer #(.W(CW), .RST_VAL('0)) u_wait (
    .clk(clk), .rst(rst), .load(wt_load), .load_val(CW'(C_TMO)), .done(wt_done)
  );

  assign timeout  = TMO_EN && wt_done;
  assign tx_ready = (state == ST_IDLE) && !dir_q && (dir_sel == dir_q) && settle_done;

  always_comb begin
    state_d     = state;
    ph_load     = 1'b0;
    ph_val      = '0;
    wt_load     = 1'b0;
    settle_load = 1'b0;
    accept      = 1'b0;
    drive       = 1'b0;
    ctl_fall    = 1'b0;
    ctl_rise    = 1'b0;
    latch       = 1'b0;
    abort       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (dir_sel != dir_q) begin
          settle_load = 1'b1;
        end else if (settle_done) begin
          if (!dir_q && tx_valid) begin
            accept  = 1'b1;
            wt_load = 1'b1;
            state_d = ST_W_WAITLO;
          end else if (dir_q && !rx_valid_q) begin
            ctl_fall = 1'b1;
            wt_load  = 1'b1;
            state_d  = ST_R_WAITV;
          end
        end
      end
      ST_W_WAITLO: begin
        if (!flag_s) begin
          ph_load = 1'b1;
          ph_val  = CW'(C_SETUP);
          state_d = ST_W_SETUP;
        end else if (timeout) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_W_SETUP: begin
        if (ph_done) begin
          drive   = 1'b1;
          ph_load = 1'b1;
          ph_val  = CW'(C_HOLD);
          state_d = ST_W_HOLD;
        end
      end
      ST_W_HOLD: begin
        if (ph_done) begin
          ctl_fall = 1'b1;
          ph_load  = 1'b1;
          ph_val   = CW'(C_GAP);
          state_d  = ST_W_GAP;
        end
      end
      ST_W_GAP: begin
        if (ph_done) begin
          wt_load = 1'b1;
          state_d = ST_W_WAITHI;
        end
      end
      ST_W_WAITHI: begin
        if (flag_s) begin
          ph_load = 1'b1;
          ph_val  = CW'(C_RET);
          state_d = ST_W_RET;
        end else if (timeout) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_W_RET: begin
        if (ph_done) begin
          ctl_rise = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_R_WAITV: begin
        if (!flag_s) begin
          latch    = 1'b1;
          ctl_rise = 1'b1;
          wt_load  = 1'b1;
          state_d  = ST_R_WAITI;
        end else if (timeout) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_R_WAITI: begin
        if (flag_s) begin
          state_d = ST_IDLE;
        end else if (timeout) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dir_q      <= 1'b1;
      ctl_q      <= 1'b1;
      oe_q       <= 1'b0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      rx_valid_q <= 1'b0;
      tx_word    <= '0;
      bus_q      <= '0;
      rx_data_q  <= '0;
    end else begin
      state  <= state_d;
      busy_q <= (state_d != ST_IDLE);
      err_q  <= abort;
      if (settle_load) begin
        dir_q <= dir_sel;
        if (dir_sel) oe_q <= 1'b0;
      end
      if (accept) tx_word <= tx_data;
      if (drive) begin
        bus_q <= tx_word;
        oe_q  <= 1'b1;
      end
      if (ctl_fall) ctl_q <= 1'b0;
      if (ctl_rise) ctl_q <= 1'b1;
      if (abort) begin
        ctl_q <= 1'b1;
        oe_q  <= 1'b0;
      end
      if (latch) begin
        rx_data_q  <= bus_in;
        rx_valid_q <= 1'b1;
      end else if (rx_valid_q && rx_ready) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  assign port_dir = dir_q;
  assign port_ctl = ctl_q;
  assign bus_oe   = oe_q;
  assign bus_out  = bus_q;
  assign busy     = busy_q;
  assign err      = err_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
endmodule

// File: rtl/pport_hs_chk.sv
module pport_hs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          port_ctl,
  input logic          port_dir,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          busy,
  input logic          err,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data
);
  // R6: strobe is high whenever no transfer is running
  a_r6_ctl_high_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> port_ctl);

  // R8: bus released in read direction
  a_r8_tristate_in_read: assert property (@(posedge clk) disable iff (rst)
    port_dir |-> !bus_oe);

  // R9: direction frozen during a transfer
  a_r9_dir_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(port_dir));

  // R4: write data does not move while the strobe is low
  a_r4_data_stable_ctl_low: assert property (@(posedge clk) disable iff (rst)
    (!port_ctl && !port_dir) |=> $stable(bus_out));

  // R7: received word held until taken
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R10: error pulse lasts one cycle
  a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R10: abort leaves the port idle with the bus released
  a_r10_abort_release: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (port_ctl && !bus_oe && !busy));
endmodule

bind pport_hs pport_hs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .port_ctl(port_ctl), .port_dir(port_dir),
  .bus_oe(bus_oe), .bus_out(bus_out), .busy(busy), .err(err),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/sim_pport_hs.sv
`timescale 1ns/1ps
module sim_pport_hs;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_sel = 1'b1;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic          busy, err, port_dir, port_ctl, bus_oe;
  logic          port_flag = 1'b1;
  logic [DW-1:0] bus_out;
  logic [DW-1:0] bus_in = '0;

  int  checks = 0;
  int  errors = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pport_hs #(
    .DW(DW), .CLK_HZ(1_000_000), .TIMEOUT_US(500)
  ) u0 (
    .clk(clk), .rst(rst), .dir_sel(dir_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy), .err(err),
    .port_dir(port_dir), .port_ctl(port_ctl), .port_flag(port_flag),
    .bus_oe(bus_oe), .bus_out(bus_out), .bus_in(bus_in)
  );

  task automatic chk_eq(input string req, input string what,
                        input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what,
                         input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    chk_eq("R1", "ctl", port_ctl, 1);
    chk_eq("R1", "dir", port_dir, 1);
    chk_eq("R1", "oe", bus_oe, 0);
    chk_eq("R1", "busy", busy, 0);
    chk_eq("R1", "err", err, 0);
    chk_eq("R1", "rx_valid", rx_valid, 0);
  endtask

  task automatic t_to_write();
    longint t0, t1;
    dir_sel = 1'b0;
    while (port_dir != 1'b0) @(negedge clk);
    t0 = cyc;
    tx_data  = 8'hA5;
    tx_valid = 1'b1;
    repeat (500) @(negedge clk);
    chk_eq("R2", "busy during settle", busy, 0);
    while (!tx_ready) @(negedge clk);
    t1 = cyc;
    chk_rng("R2", "settle cycles", t1 - t0, 1000, 1002);
  endtask

  task automatic t_write(input logic [DW-1:0] d, input bit fast);
    longint tf, td, tc, tr, th;
    tx_data  = d;
    tx_valid = 1'b1;
    while (!busy) @(negedge clk);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R3", "ctl before flag", port_ctl, 1);
    chk_eq("R3", "word not driven before flag", (bus_oe && bus_out == d), 0);
    port_flag = 1'b0;
    tf = cyc;
    while (!(bus_oe && bus_out == d)) @(negedge clk);
    td = cyc;
    chk_rng("R3", "flag low to data", td - tf, 40, 46);
    while (port_ctl) @(negedge clk);
    tc = cyc;
    chk_rng("R4", "data to ctl low", tc - td, 30, 33);
    if (fast) begin
      port_flag = 1'b1;
      tr = tc;
    end else begin
      repeat (100) @(negedge clk);
      chk_eq("R5", "ctl low while flag low", port_ctl, 0);
      port_flag = 1'b1;
      tr = cyc;
    end
    while (!port_ctl) @(negedge clk);
    th = cyc;
    if (fast) chk_rng("R5", "ctl low width, early ack", th - tc, 75, 81);
    else      chk_rng("R6", "flag high to ctl high", th - tr, 35, 41);
    chk_eq("R6", "busy after ctl high", busy, 0);
  endtask

  task automatic t_timeout_low();
    longint tb, te;
    tx_data  = 8'h99;
    tx_valid = 1'b1;
    while (!busy) @(negedge clk);
    tb = cyc;
    tx_valid = 1'b0;
    while (!err) @(negedge clk);
    te = cyc;
    chk_rng("R10", "wait-low timeout cycles", te - tb, 500, 503);
    chk_eq("R10", "ctl after abort", port_ctl, 1);
    chk_eq("R10", "oe after abort", bus_oe, 0);
    chk_eq("R10", "busy after abort", busy, 0);
    @(negedge clk);
    chk_eq("R10", "err width", err, 0);
  endtask

  task automatic t_timeout_high();
    tx_data  = 8'h66;
    tx_valid = 1'b1;
    while (!busy) @(negedge clk);
    tx_valid  = 1'b0;
    port_flag = 1'b0;
    while (port_ctl) @(negedge clk);
    while (!err) @(negedge clk);
    chk_eq("R10", "oe after ack timeout", bus_oe, 0);
    chk_eq("R10", "ctl after ack timeout", port_ctl, 1);
    port_flag = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_read();
    longint t0, t1;
    dir_sel = 1'b1;
    while (port_dir != 1'b1) @(negedge clk);
    t0 = cyc;
    chk_eq("R8", "oe in read", bus_oe, 0);
    while (port_ctl) @(negedge clk);
    t1 = cyc;
    chk_rng("R2", "settle before read ready", t1 - t0, 1000, 1003);
    chk_eq("R7", "busy while ready", busy, 1);
    repeat (10) @(negedge clk);
    bus_in    = 8'h5A;
    port_flag = 1'b0;
    while (!rx_valid) @(negedge clk);
    chk_eq("R7", "rx_data", rx_data, 8'h5A);
    chk_eq("R7", "ctl after latch", port_ctl, 1);
    bus_in = 8'h00;
    repeat (3) @(negedge clk);
    port_flag = 1'b1;
    repeat (30) @(negedge clk);
    chk_eq("R7", "no new read while unread", port_ctl, 1);
    chk_eq("R7", "rx_valid held", rx_valid, 1);
    chk_eq("R7", "rx_data held", rx_data, 8'h5A);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk_eq("R7", "rx_valid cleared", rx_valid, 0);
  endtask

  task automatic t_dir_hold();
    while (port_ctl) @(negedge clk);
    dir_sel = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R9", "dir held while busy", port_dir, 1);
    chk_eq("R9", "ctl still ready", port_ctl, 0);
    bus_in    = 8'hC3;
    port_flag = 1'b0;
    while (!rx_valid) @(negedge clk);
    chk_eq("R7", "second rx_data", rx_data, 8'hC3);
    chk_eq("R9", "dir held until idle", port_dir, 1);
    repeat (3) @(negedge clk);
    port_flag = 1'b1;
    while (port_dir != 1'b0) @(negedge clk);
    chk_eq("R9", "dir changed when idle", busy, 0);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_to_write();
    t_write(8'hA5, 1'b1);
    t_write(8'h3C, 1'b0);
    t_timeout_low();
    t_timeout_high();
    t_read();
    t_dir_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule